// File: doc/BRIEF.md
# Banked Change-of-State Interrupt Controller

This block watches 48 digital input lines, organised as six banks of eight. Bank n holds lines 8n to 8n+7. Each line first passes through a two-stage synchroniser. When any line in a bank changes level, rising or falling, and that bank is enabled, the block latches a pending flag for the bank. It also raises a single shared interrupt request while any enabled bank has a pending flag.

A host reaches the block over a small 8-bit port-style bus with a 3-bit address, a read strobe, a write strobe and write data. Read data is combinational and only valid while the read strobe is high. Offsets 0 to 2 and 4 to 6 return the synchronised line levels, one byte at a time. Offset 7 has two roles. A read returns the bank status byte and clears the pending flags at the clock edge that ends the read. A write loads the per-bank enable mask.

A typical bring-up writes 0 to offset 7 and then reads offset 7 once to discard any stale pending flags. The handler reads offset 7 to learn which banks fired, then reads the level bytes of those banks.

Top module: `cos_bank_irq`

## Requirements
- R1: After reset, all bank enables and pending flags are 0, `irqReq` is low, and a read of offset 7 returns 8'h40.
- R2: Reads of offsets 0, 1 and 2 return synchronised lines [7:0], [15:8] and [23:16]. Reads of offsets 4, 5 and 6 return lines [31:24], [39:32] and [47:40]. Offset 3 reads 8'h00.
- R3: A write to offset 7 loads the bank enable mask from data bits [5:0], where bit n enables bank n. Bit 7 of the offset-7 read value is 1 exactly when at least one enable bit is 1.
- R4: A level change in either direction on any line of an enabled bank n sets pending flag n. Flag n reads back as bit n of offset 7.
- R5: Level changes on lines of a bank whose enable bit is 0 set no pending flag.
- R6: `irqReq` is high exactly when some bank has both its pending flag and its enable set. Bit 6 of the offset-7 read value is the inverse of `irqReq`, so 0 means a request is active.
- R7: A read of offset 7 returns the pending flags as they were before the read. All flags are cleared at the clock edge that ends the read.
- R8: If a bank's edge is seen in the same cycle as a clearing read, that bank's flag is 1 after the read, so the event is not lost.
- R9: Writes to offsets 0 to 6 change neither the enable mask nor the pending flags.
- R10: A pending flag stays latched while its bank is disabled, without driving `irqReq`. Re-enabling the bank raises `irqReq` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineIn | input | 48 | Asynchronous digital input lines |
| busAddr | input | 3 | Register offset |
| busRd | input | 1 | Read strobe; a read of offset 7 clears pending flags at the edge |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid while `busRd` is high, 0 otherwise |
| irqReq | output | 1 | Shared interrupt request, active high |

## Verification
The assertions rely on two things. Read and write strobes never assert together. A status read lasts exactly one clock, so each read clears once. The bench drives every bus access as a one-cycle strobe, starting at a falling edge. It changes input lines only at falling edges, and it changes the enable mask only after the synchroniser has settled, so the reference model can predict exactly which bank events are latched. The coincident-edge case is forced by timing a status read against the synchroniser depth.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;

  // Strobes passed from bus decode to the event datapath
  typedef struct packed {
    logic statusRead;   // clearing read of the status offset this cycle
    logic enableWrite;  // load of the bank enable mask this cycle
  } ctlStrobe_t;

endpackage

// File: rtl/cos_irq_datapath.sv
module cos_irq_datapath
  import cos_irq_pkg::*;
#(
  parameter int NUM_BANKS   = 6,
  parameter int BANK_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LINES      = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LINES-1:0]     lineIn,
  input  ctlStrobe_t           strobe,
  input  logic [NUM_BANKS-1:0] wrEnable,
  output logic [LINES-1:0]     syncLines,
  output logic [NUM_BANKS-1:0] pendQ,
  output logic [NUM_BANKS-1:0] bankEn,
  output logic                 irqOut
);

  logic [LINES-1:0]     stageQ [SYNC_STAGES];
  logic [LINES-1:0]     prevQ;
  logic [NUM_BANKS-1:0] edgeBank;
  logic [NUM_BANKS-1:0] pendNext;

  // Input synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '{default: '0};
    end else begin
      stageQ[0] <= lineIn;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncLines = stageQ[SYNC_STAGES-1];

  // Previous synchronised value for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncLines;
  end

  // One change detector per bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign edgeBank[b] = |(syncLines[b*BANK_W +: BANK_W] ^ prevQ[b*BANK_W +: BANK_W]);
  end

  // Enable mask register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   bankEn <= '0;
    else if (strobe.enableWrite) bankEn <= wrEnable;
  end

  // Pending flags: a clearing read never masks an event from the same cycle
  assign pendNext = (pendQ & ~{NUM_BANKS{strobe.statusRead}}) | (edgeBank & bankEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendNext;
  end

  assign irqOut = |(pendQ & bankEn);

  // R5: a flag can only rise for a bank that was enabled
  a_r5_no_set_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ & ~$past(pendQ) & ~$past(bankEn)) == '0);

  // R4 / R8: an enabled edge always leaves its flag set, read or not
  a_r8_edge_survives_clear: assert property (@(posedge clk) disable iff (!rstN)
    (edgeBank & bankEn) != '0 |=> (pendQ & $past(edgeBank & bankEn)) == $past(edgeBank & bankEn));

  // R7: a clearing read with no concurrent edge empties all flags
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.statusRead && edgeBank == '0) |=> pendQ == '0);

  // R3: the enable mask follows the written value
  a_r3_enable_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enableWrite |=> bankEn == $past(wrEnable));

  // R6: nothing enabled means no request
  a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    bankEn == '0 |-> !irqOut);

endmodule

// File: rtl/cos_irq_control.sv
module cos_irq_control
  import cos_irq_pkg::*;
#(
  parameter int NUM_BANKS   = 6,
  parameter int BANK_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int STATUS_ADDR = 7,
  parameter int HOLE_ADDR   = 3,
  localparam int LINES      = NUM_BANKS * BANK_W,
  localparam int IRQ_BIT    = BANK_W - 2,
  localparam int EN_BIT     = BANK_W - 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busRd,
  input  logic                 busWr,
  input  logic [BANK_W-1:0]    busWdata,
  input  logic [LINES-1:0]     syncLines,
  input  logic [NUM_BANKS-1:0] pendQ,
  input  logic [NUM_BANKS-1:0] bankEn,
  input  logic                 irqOut,
  output logic [BANK_W-1:0]    busRdata,
  output ctlStrobe_t           strobe,
  output logic [NUM_BANKS-1:0] wrEnable
);

  logic statusHit;
  logic holeHit;
  int   byteIdx;

  assign statusHit = (busAddr == ADDR_W'(STATUS_ADDR));
  assign holeHit   = (busAddr == ADDR_W'(HOLE_ADDR));

  assign strobe.statusRead  = busRd && statusHit;
  assign strobe.enableWrite = busWr && statusHit;
  assign wrEnable           = busWdata[NUM_BANKS-1:0];

  // Level bytes sit below and above the unused hole offset
  always_comb begin
    if (int'(busAddr) < HOLE_ADDR) byteIdx = int'(busAddr);
    else                           byteIdx = int'(busAddr) - 1;
  end

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      if (statusHit) begin
        busRdata[NUM_BANKS-1:0] = pendQ;
        busRdata[IRQ_BIT]       = ~irqOut;
        busRdata[EN_BIT]        = |bankEn;
      end else if (!holeHit && byteIdx < NUM_BANKS) begin
        busRdata = syncLines[byteIdx*BANK_W +: BANK_W];
      end
    end
  end

  // The bus never reads and writes at once
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  // R2: the unused offset always returns zero
  a_r2_hole_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && holeHit) |-> busRdata == '0);

endmodule

// File: rtl/cos_bank_irq.sv
module cos_bank_irq
  import cos_irq_pkg::*;
#(
  parameter int NUM_BANKS   = 6,
  parameter int BANK_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3,
  parameter int STATUS_ADDR = 7,
  parameter int HOLE_ADDR   = 3,
  localparam int LINES      = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  lineIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [BANK_W-1:0] busWdata,
  output logic [BANK_W-1:0] busRdata,
  output logic              irqReq
);

  ctlStrobe_t           strobe;
  logic [NUM_BANKS-1:0] wrEnable;
  logic [LINES-1:0]     syncLines;
  logic [NUM_BANKS-1:0] pendQ;
  logic [NUM_BANKS-1:0] bankEn;

  cos_irq_control #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
    .STATUS_ADDR(STATUS_ADDR), .HOLE_ADDR(HOLE_ADDR)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .syncLines(syncLines), .pendQ(pendQ), .bankEn(bankEn),
    .irqOut(irqReq), .busRdata(busRdata), .strobe(strobe), .wrEnable(wrEnable)
  );

  cos_irq_datapath #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .strobe(strobe), .wrEnable(wrEnable),
    .syncLines(syncLines), .pendQ(pendQ), .bankEn(bankEn), .irqOut(irqReq)
  );

endmodule

// File: tb/cos_bank_irq_tb.sv
module cos_bank_irq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [47:0] lineIn = '0;
  logic [2:0]  busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        irqReq;

  int nChecks = 0;
  int nFail   = 0;

  logic [5:0]  expEn   = '0;
  logic [5:0]  expPend = '0;

  always #10 clk = ~clk;

  cos_bank_irq dut_i (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq)
  );

  function automatic logic [5:0] banksOf(input logic [47:0] m);
    logic [5:0] r;
    for (int b = 0; b < 6; b++) r[b] = |m[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [7:0] expStatus();
    return {|expEn, ~(|(expPend & expEn)), expPend};
  endfunction

  function automatic logic [7:0] expLevel(input int a);
    if (a == 3) return 8'h00;
    if (a < 3)  return lineIn[a*8 +: 8];
    return lineIn[(a-1)*8 +: 8];
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
    if (a == 3'd7) expEn = d[5:0];
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #2 d = busRdata;
    @(posedge clk); #1;
    busRd = 1'b0;
    if (a == 3'd7) expPend = '0;
  endtask

  task automatic readStatus(input string tag);
    logic [7:0] e, d;
    e = expStatus();
    busRead(3'd7, d);
    check(tag, d, e);
  endtask

  task automatic flipSettle(input logic [47:0] m);
    @(negedge clk);
    lineIn = lineIn ^ m;
    repeat (4) @(posedge clk);
    expPend = expPend | (banksOf(m) & expEn);
  endtask

  task automatic checkIrq(input string tag);
    @(negedge clk);
    check(tag, {7'd0, irqReq}, {7'd0, |(expPend & expEn)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_c05e));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(posedge clk);

    // R1 reset state
    checkIrq("R1 irq after reset");
    readStatus("R1 status after reset");

    // R2 level readback, R5 disabled banks latch nothing
    flipSettle(48'hA53C_0FF0_9669);
    for (int a = 0; a < 7; a++) begin
      busRead(3'(a), d);
      check($sformatf("R2 level offset %0d", a), d, expLevel(a));
    end
    readStatus("R5 no latch while all disabled");

    // R3 enable load and bit 7, upper data bits ignored
    busWrite(3'd7, 8'h15);
    readStatus("R3 enable 0x15");
    busWrite(3'd7, 8'hFF);
    readStatus("R3 enable all");

    // R9 writes elsewhere have no effect
    for (int a = 0; a < 7; a++) busWrite(3'(a), 8'h00);
    readStatus("R9 enable kept after other writes");
    checkIrq("R9 irq quiet after other writes");

    // R4 rising then falling in bank 2, R6 and R7
    flipSettle(48'h1 << 17);
    checkIrq("R6 irq raised by bank 2");
    readStatus("R4 rising edge bank 2");
    readStatus("R7 cleared after read");
    checkIrq("R6 irq low after clear");
    flipSettle(48'h1 << 17);
    readStatus("R4 falling edge bank 2");

    // R5 disabled bank ignored
    busWrite(3'd7, 8'h01);
    flipSettle(48'h1 << 40);
    checkIrq("R5 irq quiet for disabled bank 5");
    readStatus("R5 status for disabled bank 5");

    // R10 flag held while disabled, re-enable raises request
    busWrite(3'd7, 8'h3F);
    flipSettle(48'h1 << 9);
    busWrite(3'd7, 8'h3D);
    checkIrq("R10 irq masked while bank 1 disabled");
    busWrite(3'd7, 8'h3F);
    checkIrq("R10 irq back after re-enable");
    readStatus("R10 flag kept through disable");

    // R8 edge coinciding with the clearing read
    flipSettle(48'h1);
    @(negedge clk);
    lineIn = lineIn ^ 48'h2;
    @(posedge clk); @(negedge clk); @(posedge clk);
    @(negedge clk);
    busAddr = 3'd7; busRd = 1'b1;
    #2 d = busRdata;
    check("R8 read before coincident clear", d, expStatus());
    @(posedge clk); #1 busRd = 1'b0;
    expPend = 6'h01;
    checkIrq("R8 irq kept after coincident clear");
    readStatus("R8 flag kept after coincident clear");

    // Random mix
    for (int it = 0; it < 80; it++) begin
      logic [47:0] m;
      if ($urandom_range(0, 3) == 0) busWrite(3'd7, 8'($urandom));
      m = '0;
      for (int k = 0; k < int'($urandom_range(0, 3)); k++) m[$urandom_range(0, 47)] = 1'b1;
      flipSettle(m);
      checkIrq("R6 random irq");
      if ($urandom_range(0, 1) == 1) readStatus("R4 random status");
      begin
        int a;
        a = $urandom_range(0, 6);
        busRead(3'(a), d);
        check("R2 random level", d, expLevel(a));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule